// File: doc/BRIEF.md
# Line and Frame Interrupt Controller

This block turns the timing events of a raster video generator into interrupt requests for a CPU. A down-counter, reloaded from an 8-bit interval register, measures out groups of active lines and requests a line interrupt each time a group ends. A separate pulse that marks the start of vertical blanking requests a frame interrupt. The two sources are presented to the CPU as one encoded priority level: 6 for the frame source, 4 for the line source, and 0 when nothing is due.

Each source has its own pending bit. The bit latches whether or not the source is enabled. The enable bits only gate what reaches the level output, so a request that arrived while its source was masked is delivered as soon as software sets the enable. The CPU clears a source by presenting the level it is servicing on the acknowledge input. The frame pending bit is also brought out directly so that it can be placed in a status word.

Top module: `irq_line_frame_ctl`

## Requirements
- R1: After reset `irqLevel` is 0, `framePending` is 0, both pending bits are clear and the line counter holds 0.
- R2: On an end-of-line strobe for an active line (line number 0 to 224), a counter value of 0 raises a line request and reloads the counter from `lineReload`. Any other counter value is decremented by one. An end-of-line strobe on a line above 224 only reloads the counter. A reload value N therefore gives one request every N+1 active lines: the lines k with (k+1) mod (N+1) = 0.
- R3: With `lineReload` = 0, every active line 0 through 224 raises one line request, which makes 225 per frame. The first is on line 0 and the last is on line 224.
- R4: A line request sets the line pending bit even when `lineIrqEn` is 0, and the level output then stays 0. The bit stays set across later lines. When the enable is later set, level 4 appears, and after one acknowledge it does not appear again.
- R5: A `frameStart` pulse sets the frame pending bit regardless of `frameIrqEn`. `framePending` shows that bit and stays 1 until a level-6 acknowledge clears it.
- R6: When `frameIrqEn` is raised while the frame pending bit is set, `irqLevel` becomes 6 in that same cycle.
- R7: `irqLevel` is 6 whenever the frame source is pending and enabled. Otherwise it is 4 when the line source is pending and enabled, and 0 in all other cases. No other value appears.
- R8: An acknowledge (`ackValid` = 1) clears only the pending bit of the source whose level is on `ackLevel`. `irqLevel` then falls to the other source's level if that source is pending and enabled, and to 0 otherwise.
- R9: A set and an acknowledge of the same source in the same cycle leave its pending bit set.
- R10: An acknowledge that carries a level other than 4 or 6 changes no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineEnd | input | 1 | One-cycle strobe at the end of each line |
| lineNum | input | 9 | Number of the line that is ending |
| frameStart | input | 1 | One-cycle pulse at the start of vertical blanking |
| lineReload | input | 8 | Line interval reload value |
| lineIrqEn | input | 1 | Line interrupt enable |
| frameIrqEn | input | 1 | Frame interrupt enable |
| ackValid | input | 1 | Acknowledge strobe from the CPU |
| ackLevel | input | 3 | Level being acknowledged |
| irqLevel | output | 3 | Encoded interrupt level: 0, 4 or 6 |
| framePending | output | 1 | Frame pending flag for the status word |

## Verification
A strobe or acknowledge that is sampled at a rising edge changes the pending bits at that edge. The new `irqLevel` and `framePending` are therefore due one cycle after the stimulus. A change of an enable bit, in contrast, reaches `irqLevel` in the same cycle, because the level is decoded without a register from the pending bits and the enables. The bench applies inputs after the falling edge and reads the outputs at the next falling edge, so each result is taken exactly one rising edge after its cause. On every cycle it also compares both outputs against a cycle model derived from the requirements. The per-frame counts and the first and last interrupt lines are recorded by an interrupt-servicing loop that acknowledges whatever level it sees.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes from the control half to the pending-bit datapath
  typedef struct packed {
    logic lineSet;
    logic frameSet;
    logic lineAck;
    logic frameAck;
  } irqStrobes_t;

endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int RELOAD_W    = 8,
  parameter int ACTIVE_LAST = 224,
  parameter int LEVEL_W     = 3,
  parameter int LINE_LEVEL  = 4,
  parameter int FRAME_LEVEL = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineEnd,
  input  logic [LINE_W-1:0]   lineNum,
  input  logic                frameStart,
  input  logic [RELOAD_W-1:0] lineReload,
  input  logic                ackValid,
  input  logic [LEVEL_W-1:0]  ackLevel,
  output irqStrobes_t         strobes
);

  localparam logic [LINE_W-1:0]  LAST_ACTIVE = LINE_W'(ACTIVE_LAST);
  localparam logic [LEVEL_W-1:0] LVL_LINE    = LEVEL_W'(LINE_LEVEL);
  localparam logic [LEVEL_W-1:0] LVL_FRAME   = LEVEL_W'(FRAME_LEVEL);

  logic [RELOAD_W-1:0] downCnt;
  logic                inActive;
  logic                cntZero;

  always_comb begin
    inActive = (lineNum <= LAST_ACTIVE);
    cntZero  = (downCnt == '0);
  end

  // Interval counter: count down over active lines, reload on underflow
  // and on every line outside the active region.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      downCnt <= '0;
    end else if (lineEnd) begin
      if (inActive && !cntZero) downCnt <= downCnt - 1'b1;
      else                      downCnt <= lineReload;
    end
  end

  always_comb begin
    strobes.lineSet  = lineEnd && inActive && cntZero;
    strobes.frameSet = frameStart;
    strobes.lineAck  = ackValid && (ackLevel == LVL_LINE);
    strobes.frameAck = ackValid && (ackLevel == LVL_FRAME);
  end

endmodule

// File: rtl/irq_dpath.sv
module irq_dpath
  import irq_pkg::*;
#(
  parameter int LEVEL_W     = 3,
  parameter int LINE_LEVEL  = 4,
  parameter int FRAME_LEVEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobes_t        strobes,
  input  logic               lineIrqEn,
  input  logic               frameIrqEn,
  output logic [LEVEL_W-1:0] irqLevel,
  output logic               framePending
);

  // Source index 0 = line, 1 = frame (frame wins)
  localparam int NSRC = 2;

  logic [NSRC-1:0] setV, ackV, enV, pendQ, activeV;

  always_comb begin
    setV = {strobes.frameSet, strobes.lineSet};
    ackV = {strobes.frameAck, strobes.lineAck};
    enV  = {frameIrqEn, lineIrqEn};
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    // A set in the same cycle as an acknowledge keeps the bit
    always_ff @(posedge clk) begin
      if (!rstN) pendQ[g] <= 1'b0;
      else       pendQ[g] <= setV[g] | (pendQ[g] & ~ackV[g]);
    end
    assign activeV[g] = pendQ[g] & enV[g];
  end

  always_comb begin
    if (activeV[1])      irqLevel = LEVEL_W'(FRAME_LEVEL);
    else if (activeV[0]) irqLevel = LEVEL_W'(LINE_LEVEL);
    else                 irqLevel = '0;
  end

  assign framePending = pendQ[1];

endmodule

// File: rtl/irq_line_frame_ctl.sv
module irq_line_frame_ctl
  import irq_pkg::*;
#(
  parameter int LINE_W      = 9,
  parameter int RELOAD_W    = 8,
  parameter int ACTIVE_LAST = 224,
  parameter int LEVEL_W     = 3,
  parameter int LINE_LEVEL  = 4,
  parameter int FRAME_LEVEL = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineEnd,
  input  logic [LINE_W-1:0]   lineNum,
  input  logic                frameStart,
  input  logic [RELOAD_W-1:0] lineReload,
  input  logic                lineIrqEn,
  input  logic                frameIrqEn,
  input  logic                ackValid,
  input  logic [LEVEL_W-1:0]  ackLevel,
  output logic [LEVEL_W-1:0]  irqLevel,
  output logic                framePending
);

  irqStrobes_t strobes;

  irq_ctrl #(
    .LINE_W(LINE_W), .RELOAD_W(RELOAD_W), .ACTIVE_LAST(ACTIVE_LAST),
    .LEVEL_W(LEVEL_W), .LINE_LEVEL(LINE_LEVEL), .FRAME_LEVEL(FRAME_LEVEL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .lineEnd(lineEnd), .lineNum(lineNum),
    .frameStart(frameStart), .lineReload(lineReload),
    .ackValid(ackValid), .ackLevel(ackLevel), .strobes(strobes)
  );

  irq_dpath #(
    .LEVEL_W(LEVEL_W), .LINE_LEVEL(LINE_LEVEL), .FRAME_LEVEL(FRAME_LEVEL)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lineIrqEn(lineIrqEn), .frameIrqEn(frameIrqEn),
    .irqLevel(irqLevel), .framePending(framePending)
  );

endmodule

// File: rtl/irq_checker.sv
module irq_checker #(
  parameter int LEVEL_W     = 3,
  parameter int LINE_LEVEL  = 4,
  parameter int FRAME_LEVEL = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               frameStart,
  input logic               lineIrqEn,
  input logic               frameIrqEn,
  input logic               ackValid,
  input logic [LEVEL_W-1:0] ackLevel,
  input logic [LEVEL_W-1:0] irqLevel,
  input logic               framePending
);

  localparam logic [LEVEL_W-1:0] LVL_LINE  = LEVEL_W'(LINE_LEVEL);
  localparam logic [LEVEL_W-1:0] LVL_FRAME = LEVEL_W'(FRAME_LEVEL);

  a_r7_frame_wins: assert property (@(posedge clk) disable iff (!rstN)
    (framePending && frameIrqEn) |-> irqLevel == LVL_FRAME);

  a_r7_legal_level: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == '0) || (irqLevel == LVL_LINE) || (irqLevel == LVL_FRAME));

  a_r5_frame_latch: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> framePending);

  a_r5_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    (framePending && !(ackValid && ackLevel == LVL_FRAME)) |=> framePending);

  a_r8_frame_clear: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackLevel == LVL_FRAME && !frameStart) |=> !framePending);

  a_r4_line_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!lineIrqEn && !(framePending && frameIrqEn)) |-> irqLevel == '0);

  a_r6_late_enable: assert property (@(posedge clk) disable iff (!rstN)
    (framePending && $rose(frameIrqEn)) |-> irqLevel == LVL_FRAME);

endmodule

bind irq_line_frame_ctl irq_checker #(
  .LEVEL_W(LEVEL_W), .LINE_LEVEL(LINE_LEVEL), .FRAME_LEVEL(FRAME_LEVEL)
) i_checker (
  .clk(clk), .rstN(rstN), .frameStart(frameStart),
  .lineIrqEn(lineIrqEn), .frameIrqEn(frameIrqEn),
  .ackValid(ackValid), .ackLevel(ackLevel),
  .irqLevel(irqLevel), .framePending(framePending)
);

// File: tb/test_irq_line_frame_ctl.sv
module test_irq_line_frame_ctl;

  localparam int CLK_PERIOD  = 10;
  localparam int ACTIVE_LAST = 224;
  localparam int TOTAL_LINES = 262;
  localparam int CPL         = 3;   // cycles per line

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineEnd = 1'b0;
  logic [8:0] lineNum = '0;
  logic       frameStart = 1'b0;
  logic [7:0] lineReload = '0;
  logic       lineIrqEn = 1'b0;
  logic       frameIrqEn = 1'b0;
  logic       ackValid = 1'b0;
  logic [2:0] ackLevel = '0;
  logic [2:0] irqLevel;
  logic       framePending;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_line_frame_ctl i_irq_line_frame_ctl (
    .clk(clk), .rstN(rstN), .lineEnd(lineEnd), .lineNum(lineNum),
    .frameStart(frameStart), .lineReload(lineReload),
    .lineIrqEn(lineIrqEn), .frameIrqEn(frameIrqEn),
    .ackValid(ackValid), .ackLevel(ackLevel),
    .irqLevel(irqLevel), .framePending(framePending)
  );

  int nChecks = 0;
  int nFails  = 0;
  int modelErr = 0;
  bit finished = 0;

  // Requirement-derived cycle model
  int mCnt = 0;
  bit mLine = 0;
  bit mFrame = 0;

  // Servicing loop state
  bit autoAck = 0;
  int lineIrqs, frameIrqs, firstLine, lastLine;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expLevel();
    if (mFrame && frameIrqEn) return 3'd6;
    if (mLine && lineIrqEn)   return 3'd4;
    return 3'd0;
  endfunction

  task automatic tick();
    bit ls, la, fa;
    @(posedge clk);
    ls = lineEnd && (lineNum <= ACTIVE_LAST) && (mCnt == 0);
    if (lineEnd)
      mCnt = ((lineNum <= ACTIVE_LAST) && (mCnt != 0)) ? mCnt - 1 : int'(lineReload);
    la = ackValid && (ackLevel == 3'd4);
    fa = ackValid && (ackLevel == 3'd6);
    mLine  = ls | (mLine & !la);
    mFrame = frameStart | (mFrame & !fa);
    @(negedge clk);
    if (irqLevel !== expLevel() || framePending !== mFrame) modelErr++;
    if (autoAck) begin
      ackValid = (irqLevel != 3'd0);
      ackLevel = irqLevel;
      if (irqLevel == 3'd4 && lineNum <= ACTIVE_LAST) begin
        if (lineIrqs == 0) firstLine = int'(lineNum);
        lastLine = int'(lineNum);
        lineIrqs++;
      end
      if (irqLevel == 3'd6) frameIrqs++;
    end
  endtask

  task automatic endLine(input int ln);
    lineNum = 9'(ln);
    lineEnd = 1'b1;
    tick();
    lineEnd = 1'b0;
  endtask

  task automatic ack(input logic [2:0] lvl);
    ackValid = 1'b1;
    ackLevel = lvl;
    tick();
    ackValid = 1'b0;
  endtask

  // Vertical blanking lines first (frame pulse on the first), then active lines
  task automatic runFrame(input int reload, input bit lEn, input bit fEn);
    lineReload = 8'(reload);
    lineIrqEn = lEn;
    frameIrqEn = fEn;
    lineIrqs = 0; frameIrqs = 0; firstLine = -1; lastLine = -1;
    autoAck = 1;
    for (int i = 0; i < TOTAL_LINES; i++) begin
      int ln;
      ln = (i + ACTIVE_LAST + 1) % TOTAL_LINES;
      for (int c = 0; c < CPL; c++) begin
        lineNum = 9'(ln);
        lineEnd = (c == CPL - 1);
        frameStart = (i == 0 && c == 0);
        tick();
      end
    end
    lineEnd = 1'b0;
    frameStart = 1'b0;
    autoAck = 0;
    ackValid = 1'b0;
    tick();
  endtask

  task automatic checkFrame(input int reload, input bit lEn, input bit fEn, input string tag);
    int expN, expFirst, expLast;
    expN = lEn ? (ACTIVE_LAST + 1) / (reload + 1) : 0;
    expFirst = (expN > 0) ? reload : -1;
    expLast  = (expN > 0) ? expN * (reload + 1) - 1 : -1;
    check(lineIrqs == expN, {tag, " line irq count"}, lineIrqs, expN);
    check(firstLine == expFirst, {tag, " first line"}, firstLine, expFirst);
    check(lastLine == expLast, {tag, " last line"}, lastLine, expLast);
    check(frameIrqs == (fEn ? 1 : 0), "R5 frame irq count", frameIrqs, fEn ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(irqLevel == 3'd0, "R1 reset level", irqLevel, 0);
    check(framePending == 1'b0, "R1 reset framePending", framePending, 0);

    // R4: request while masked, delivered later, exactly once
    endLine(230);
    endLine(0);
    check(irqLevel == 3'd0, "R4 masked line request", irqLevel, 0);
    repeat (2) endLine(1);
    endLine(240);
    repeat (3) tick();
    lineIrqEn = 1'b1;
    tick();
    check(irqLevel == 3'd4, "R4 late enable delivers", irqLevel, 4);
    ack(3'd4);
    check(irqLevel == 3'd0, "R8 line ack clears", irqLevel, 0);
    repeat (4) tick();
    check(irqLevel == 3'd0, "R4 fires only once", irqLevel, 0);

    // R10: acknowledge of an unused level
    endLine(230);
    endLine(0);
    check(irqLevel == 3'd4, "R2 line request at zero count", irqLevel, 4);
    ack(3'd5);
    check(irqLevel == 3'd4, "R10 level-5 ack ignored", irqLevel, 4);
    ack(3'd4);
    lineIrqEn = 1'b0;

    // R5 / R6: frame pending while masked, then enabled late
    frameStart = 1'b1; tick(); frameStart = 1'b0;
    check(framePending == 1'b1, "R5 frame pending set", framePending, 1);
    check(irqLevel == 3'd0, "R5 masked frame", irqLevel, 0);
    repeat (5) tick();
    ack(3'd4);
    check(framePending == 1'b1, "R5 held until level-6 ack", framePending, 1);
    frameIrqEn = 1'b1;
    tick();
    check(irqLevel == 3'd6, "R6 late frame enable", irqLevel, 6);

    // R7 / R8: both pending
    lineIrqEn = 1'b1;
    endLine(230);
    endLine(0);
    check(irqLevel == 3'd6, "R7 frame over line", irqLevel, 6);
    ack(3'd6);
    check(irqLevel == 3'd4, "R8 drop to line level", irqLevel, 4);
    check(framePending == 1'b0, "R8 frame cleared", framePending, 0);
    ack(3'd4);
    check(irqLevel == 3'd0, "R8 drop to zero", irqLevel, 0);

    // R9: set and acknowledge together
    frameStart = 1'b1; tick();
    ackValid = 1'b1; ackLevel = 3'd6; tick();
    frameStart = 1'b0; ackValid = 1'b0;
    check(framePending == 1'b1, "R9 frame set wins over ack", framePending, 1);
    ack(3'd6);
    endLine(230);
    endLine(0);
    endLine(230);
    ackValid = 1'b1; ackLevel = 3'd4;
    endLine(0);
    ackValid = 1'b0;
    check(irqLevel == 3'd4, "R9 line set wins over ack", irqLevel, 4);
    ack(3'd4);
    check(irqLevel == 3'd0, "R9 cleared afterwards", irqLevel, 0);

    // R2 interval 3, R3 every line
    runFrame(3, 1, 0);
    checkFrame(3, 1, 0, "R2 reload 3");
    runFrame(0, 1, 1);
    checkFrame(0, 1, 1, "R3 reload 0");
    runFrame(255, 1, 1);
    checkFrame(255, 1, 1, "R2 reload 255");

    // Random frames
    for (int f = 0; f < 8; f++) begin
      int rl;
      bit le, fe;
      rl = ($urandom % 4 == 0) ? int'($urandom % 256) : int'($urandom % 30);
      le = $urandom % 4 != 0;
      fe = $urandom % 2 == 1;
      runFrame(rl, le, fe);
      checkFrame(rl, le, fe, "R2 random frame");
    end

    check(modelErr == 0, "R7 cycle model mismatches", modelErr, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule